// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers interrupt sources into banks of 32 and raises one summary line per bank toward a parent interrupt controller. Every source passes through a two-stage synchronizer and is then detected either as a level or as an edge, with a polarity choice. Together these give four trigger types for each source. Edge events are held in a sticky pending bit until software acknowledges them. Level sources show as pending for as long as the input is active. Software can also raise any source by writing a mask.

A small register bus carries a byte address, a write strobe, write data and registered read data. It reaches six word registers in every bank. The banks repeat at a stride of 0x18 bytes. Each bank also reports the index of its highest-numbered unmasked pending source, with a valid flag, so that a handler can service the most significant source first without scanning the status word.

Top module: `intc_top`

## Requirements
- R1: Bank n starts at byte address n*0x18. Word offsets within a bank are: 0x00 masked status (read-only, writes ignored), 0x04 enable, 0x08 set (reads return raw pending), 0x0C clear (reads return zero), 0x10 polarity, 0x14 edge select. Read data appears on the cycle after the address is presented. Addresses beyond the last bank read as zero.
- R2: After synchronous reset, enable, polarity, edge select, latched pending and read data are all zero, every summary line is low and every valid flag is low.
- R3: Masked status equals pending AND enable. A source whose enable bit is 0 never shows in status, in the summary line or in the index.
- R4: Each source's edge/polarity bit pair selects its trigger type: 0/1 active-high level, 0/0 active-low level, 1/1 rising edge, 1/0 falling edge.
- R5: An input change shows in a level source's pending state two clock edges after it is driven. A qualifying edge is latched one edge after that, three edges in total.
- R6: A latched edge stays pending after the input returns to its idle level, until it is cleared.
- R7: Writing the clear register removes latched pending for each bit written as 1. Bits written as 0 have no effect. A level source whose input is still active stays pending. An edge arriving in the same cycle as its clear is kept.
- R8: Writing 1s to the set register latches those sources as pending until they are cleared, whatever their trigger type.
- R9: Each bank's summary output is high exactly when that bank's masked status is nonzero, independently of the other banks.
- R10: Each bank's index output gives the position of the most significant set bit of its masked status, with valid high. When the status is zero, valid is low and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Asynchronous interrupt sources, bank b at bits [b*32 +: 32] |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, registered one cycle after the address |
| irq_o | output | NUM_BANKS | Per-bank summary interrupt to the parent controller |
| top_idx_o | output | NUM_BANKS*5 | Per-bank index of highest pending source, bank b at [b*5 +: 5] |
| top_valid_o | output | NUM_BANKS | Per-bank flag that the index is meaningful |

## Verification
The hardest case to reach is a falling-edge source that must latch on the release of its input and not on the press. It then has to survive the return to idle, and a clear written with the wrong mask must leave it set. The stimulus programs polarity before edge select, so that no spurious event is latched during the change of mode. It pulses and releases single source bits and then reads status through the bus at chosen cycles. A behavioural model tracks every bank's synchronizer stages and latches, and it compares the summary lines, indices and read data on every clock. The number of clock edges between a source change and its effect is checked one edge at a time.

// File: rtl/intc_pkg.sv
// Shared constants and the register-select type for the banked interrupt controller.
package intc_pkg;
    localparam int SRC_W      = 32;
    localparam int IDX_W      = $clog2(SRC_W);
    localparam int BANK_BYTES = 24;

    typedef enum logic [2:0] {
        RSEL_STATUS = 3'd0,
        RSEL_ENABLE = 3'd1,
        RSEL_SET    = 3'd2,
        RSEL_CLEAR  = 3'd3,
        RSEL_POL    = 3'd4,
        RSEL_EDGE   = 3'd5
    } rsel_e;
endpackage

// File: rtl/intc_sync.sv
// Two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_r;
    logic [W-1:0] sync_r;

    // Capture the raw input, then retime it once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_r <= '0;
            sync_r <= '0;
        end else begin
            meta_r <= d_i;
            sync_r <= meta_r;
        end
    end

    assign q_o = sync_r;
endmodule

// File: rtl/intc_prio.sv
// Reports the position of the most significant set bit of a vector.
// Assumes the result is consumed combinationally; index is 0 when nothing is set.
module intc_prio #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);
    // Scan upward so that the highest set bit is the last one taken.
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o   = IW'(i);
                valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
// One bank of 32 interrupt sources: trigger detection, pending latch,
// masking, summary line and top-index encoder, plus its register file.
// Assumes at most one register write per cycle (single bus port).
module intc_bank
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             we_i,
    input  rsel_e            sel_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] rdata_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    logic [SRC_W-1:0] s_now;
    logic [SRC_W-1:0] s_prev_r;
    logic [SRC_W-1:0] en_r, pol_r, edg_r, lat_r;
    logic [SRC_W-1:0] lvl_active, det, pend, status;
    logic [SRC_W-1:0] set_m, clr_m;
    logic             set_we, clr_we;

    intc_sync #(.W(SRC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (s_now)
    );

    // Decode which masked write this cycle carries.
    always_comb begin
        set_we = we_i && (sel_i == RSEL_SET);
        clr_we = we_i && (sel_i == RSEL_CLEAR);
        set_m  = set_we ? wdata_i : '0;
        clr_m  = clr_we ? wdata_i : '0;
    end

    // Trigger detection from the edge/polarity pair of each source.
    always_comb begin
        lvl_active = ~edg_r & ~(s_now ^ pol_r);
        det        = edg_r & ((pol_r & s_now & ~s_prev_r) | (~pol_r & ~s_now & s_prev_r));
        pend       = lat_r | lvl_active;
        status     = pend & en_r;
    end

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev_r <= '0;
        else        s_prev_r <= s_now;
    end

    // Sticky latch: clear acknowledged bits, then admit new edges and software sets.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_r <= '0;
        else        lat_r <= (lat_r & ~clr_m) | det | set_m;
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_r  <= '0;
            pol_r <= '0;
            edg_r <= '0;
        end else if (we_i) begin
            if (sel_i == RSEL_ENABLE) en_r  <= wdata_i;
            if (sel_i == RSEL_POL)    pol_r <= wdata_i;
            if (sel_i == RSEL_EDGE)   edg_r <= wdata_i;
        end
    end

    // Read-side view of the bank's registers.
    always_comb begin
        case (sel_i)
            RSEL_STATUS: rdata_o = status;
            RSEL_ENABLE: rdata_o = en_r;
            RSEL_SET:    rdata_o = pend;
            RSEL_POL:    rdata_o = pol_r;
            RSEL_EDGE:   rdata_o = edg_r;
            default:     rdata_o = '0;
        endcase
    end

    assign irq_o = |status;

    intc_prio #(.W(SRC_W), .IW(IDX_W)) u_prio (
        .vec_i   (status),
        .idx_o   (idx_o),
        .valid_o (valid_o)
    );

    // R7: an acknowledged bit is gone unless a fresh edge arrived with the clear.
    p_clear_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((lat_r & $past(wdata_i) & ~$past(det)) == '0));

    // R8: a software set makes its sources pending on the next cycle.
    p_set_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pend & $past(wdata_i)) == $past(wdata_i)));

    // R6: without a clear write no latched bit may drop.
    p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((~lat_r & $past(lat_r)) == '0));

    // R9: summary line and encoder valid agree.
    p_valid_is_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == irq_o);

    // R10: the index names a set status bit with nothing above it.
    p_idx_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((status >> idx_o) == SRC_W'(1)));
endmodule

// File: rtl/intc_top.sv
// Banked interrupt controller: address decode across banks at a fixed
// stride, per-bank instances, and the registered read-data path.
// Assumes word-aligned accesses; the low two address bits are ignored.
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*SRC_W-1:0] src_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       wr_en_i,
    input  logic [SRC_W-1:0]           wr_data_i,
    output logic [SRC_W-1:0]           rd_data_o,
    output logic [NUM_BANKS-1:0]       irq_o,
    output logic [NUM_BANKS*IDX_W-1:0] top_idx_o,
    output logic [NUM_BANKS-1:0]       top_valid_o
);
    localparam int MAP_END = NUM_BANKS * BANK_BYTES;

    logic [SRC_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] hit;
    logic [SRC_W-1:0] rd_next;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b * BANK_BYTES);
        localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'((b + 1) * BANK_BYTES);
        rsel_e            sel;
        logic [SRC_W-1:0] rword;

        // Bank hit and register select from the byte offset within the bank.
        always_comb begin
            hit[b] = (addr_i >= BASE) && (addr_i < LIMIT);
            sel    = rsel_e'(3'((addr_i - BASE) >> 2));
        end

        intc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*SRC_W +: SRC_W]),
            .we_i    (wr_en_i && hit[b]),
            .sel_i   (sel),
            .wdata_i (wr_data_i),
            .rdata_o (rword),
            .irq_o   (irq_o[b]),
            .idx_o   (top_idx_o[b*IDX_W +: IDX_W]),
            .valid_o (top_valid_o[b])
        );

        assign bank_rd[b] = hit[b] ? rword : '0;
    end

    // Merge the one selected bank's word; unmapped addresses give zero.
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_next = rd_next | bank_rd[b];
    end

    // Register the read data one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_o <= '0;
        else        rd_data_o <= rd_next;
    end

    // R1: an address past the last bank returns zero on the following cycle.
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= MAP_END) |=> (rd_data_o == '0));

    // R1: at most one bank claims any address.
    p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int NB  = 5;
    localparam int AW  = 8;
    localparam int STR = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB*32-1:0] src = '0;
    logic [AW-1:0]   addr = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rd_data;
    logic [NB-1:0]   irq;
    logic [NB*5-1:0] idx;
    logic [NB-1:0]   valid;

    int ntests = 0;
    int nfail  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    intc_top #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wdata),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .top_idx_o   (idx),
        .top_valid_o (valid)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_en [NB], m_pol [NB], m_edg [NB], m_lat [NB];
    logic [31:0] m_s1 [NB], m_s2 [NB], m_prev [NB];
    logic [31:0] m_rd;

    function automatic logic [31:0] m_pend(int b);
        return m_lat[b] | (~m_edg[b] & ~(m_s2[b] ^ m_pol[b]));
    endfunction

    function automatic logic [31:0] m_status(int b);
        return m_pend(b) & m_en[b];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_en[b] = '0; m_pol[b] = '0; m_edg[b] = '0; m_lat[b] = '0;
                m_s1[b] = '0; m_s2[b] = '0; m_prev[b] = '0;
            end
            m_rd = '0;
        end else begin
            logic [31:0] rd_n;
            rd_n = '0;
            for (int b = 0; b < NB; b++) begin
                logic [31:0] det, setm, clrm;
                int off;
                setm = '0; clrm = '0;
                if (int'(addr) >= b*STR && int'(addr) < (b+1)*STR) begin
                    off = (int'(addr) - b*STR) / 4;
                    case (off)
                        0: rd_n = m_status(b);
                        1: rd_n = m_en[b];
                        2: rd_n = m_pend(b);
                        4: rd_n = m_pol[b];
                        5: rd_n = m_edg[b];
                        default: rd_n = '0;
                    endcase
                    if (wr_en) begin
                        if (off == 2) setm = wdata;
                        if (off == 3) clrm = wdata;
                    end
                end else off = -1;
                det = '0;
                for (int i = 0; i < 32; i++)
                    if (m_edg[b][i])
                        det[i] = m_pol[b][i] ? (m_s2[b][i] && !m_prev[b][i])
                                             : (!m_s2[b][i] && m_prev[b][i]);
                m_lat[b] = (m_lat[b] & ~clrm) | det | setm;
                if (wr_en && off == 1) m_en[b]  = wdata;
                if (wr_en && off == 4) m_pol[b] = wdata;
                if (wr_en && off == 5) m_edg[b] = wdata;
                m_prev[b] = m_s2[b];
                m_s2[b]   = m_s1[b];
                m_s1[b]   = src[b*32 +: 32];
            end
            m_rd = rd_n;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int b = 0; b < NB; b++) begin
                logic [31:0] st;
                int top;
                st = m_status(b);
                top = 0;
                for (int i = 0; i < 32; i++) if (st[i]) top = i;
                chk("R9", $sformatf("irq bank %0d", b), 32'(irq[b]), 32'(st != 0));
                chk("R10", $sformatf("valid bank %0d", b), 32'(valid[b]), 32'(st != 0));
                chk("R10", $sformatf("idx bank %0d", b), 32'(idx[b*5 +: 5]), 32'(top));
            end
            chk("R1", "read data", rd_data, m_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk); addr = a;
        @(negedge clk); v = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R2", "irq in reset", 32'(irq), 32'h0);
        chk("R2", "valid in reset", 32'(valid), 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        rd(8'h00, v); chk("R2", "status after reset", v, 32'h0);
        rd(8'h04, v); chk("R2", "enable after reset", v, 32'h0);
        rd(8'h10, v); chk("R2", "polarity after reset", v, 32'h0);

        // Bank 0: active-high level sources.
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0000_00FF);
        @(negedge clk); src[3] = 1'b1; src[5] = 1'b1;
        idle(3);
        rd(8'h00, v); chk("R4", "active-high level status", v, 32'h28);
        chk("R10", "bank0 top index", 32'(idx[4:0]), 32'd5);
        src[9] = 1'b1; idle(3);
        rd(8'h00, v); chk("R3", "masked source hidden", v, 32'h28);
        src[5] = 1'b0; idle(3);
        rd(8'h00, v); chk("R4", "level follows input", v, 32'h08);
        wr(8'h0C, 32'h08); idle(2);
        rd(8'h00, v); chk("R7", "active level survives clear", v, 32'h08);
        wr(8'h10, 32'hFFFF_EFFF);
        wr(8'h04, 32'h0000_10FF); idle(2);
        rd(8'h00, v); chk("R4", "active-low level status", v, 32'h1008);

        // Bank 1: rising edge on bit 0, falling edge on bit 1.
        wr(8'h28, 32'h1);
        wr(8'h2C, 32'h3);
        wr(8'h1C, 32'h3);
        @(negedge clk); src[32] = 1'b1;
        @(negedge clk); src[32] = 1'b0;
        idle(5);
        rd(8'h18, v); chk("R6", "rising edge latched and sticky", v, 32'h1);
        src[33] = 1'b1; idle(3);
        rd(8'h18, v); chk("R4", "falling source ignores rise", v, 32'h1);
        src[33] = 1'b0; idle(4);
        rd(8'h18, v); chk("R4", "falling edge latched", v, 32'h3);
        wr(8'h24, 32'h0);
        rd(8'h18, v); chk("R7", "zero clear bits no effect", v, 32'h3);
        wr(8'h24, 32'h1);
        rd(8'h18, v); chk("R7", "clear acknowledges bit 0", v, 32'h2);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R1", "status write ignored", v, 32'h2);

        // Bank 2: software set.
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h34, 32'h8000_0000);
        wr(8'h38, 32'h8000_0000);
        chk("R8", "set raises bank2 irq", 32'(irq[2]), 32'h1);
        chk("R10", "bank2 top index", 32'(idx[14:10]), 32'd31);
        chk("R9", "per-bank irq vector", 32'(irq), 32'h07);
        rd(8'h38, v); chk("R1", "set offset reads raw pending", v, 32'h8000_0000);
        rd(8'h3C, v); chk("R1", "clear offset reads zero", v, 32'h0);
        wr(8'h3C, 32'h8000_0000);
        chk("R8", "cleared software set", 32'(irq[2]), 32'h0);
        chk("R9", "other banks unaffected", 32'(irq), 32'h03);

        // Bank 3: level latency through the synchronizer.
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h4C, 32'h1);
        @(negedge clk); src[96] = 1'b1;
        @(negedge clk); chk("R5", "level after one edge", 32'(irq[3]), 32'h0);
        @(negedge clk); chk("R5", "level after two edges", 32'(irq[3]), 32'h1);

        // Bank 4: edge latency is one edge more.
        wr(8'h70, 32'h1);
        wr(8'h74, 32'h1);
        wr(8'h64, 32'h1);
        @(negedge clk); src[128] = 1'b1;
        @(negedge clk); chk("R5", "edge after one edge", 32'(irq[4]), 32'h0);
        @(negedge clk); chk("R5", "edge after two edges", 32'(irq[4]), 32'h0);
        @(negedge clk); chk("R5", "edge after three edges", 32'(irq[4]), 32'h1);

        rd(8'h7C, v); chk("R1", "unmapped address reads zero", v, 32'h0);
        rd(8'h64, v); chk("R1", "bank4 enable readback", v, 32'h1);

        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule